// File: doc/BRIEF.md
# SPI Slave Bit Engine with Hold

This block is the pin-facing front end of a serial memory's SPI target. It samples the serial clock, serial data in, active-low select and active-low hold pins on a faster system clock, through a chain of synchronizer flops. It turns the received bit stream into whole bytes for the command logic behind it, and it shifts the bytes that logic supplies out on a serial output with a separate output enable. It accepts both clock phases that sample data on the rising edge: clock idling low, and clock idling high. The clock level seen when select falls is latched as the mode flag.

The command logic gets a one-cycle pulse when a frame opens and another when it closes. With every completed byte it gets a strobe together with the byte itself. It must present the next transmit byte on `tx_byte` before the falling clock edge that begins that byte. Pulling hold low while the clock is low freezes the transfer at its current bit and floats the output. Releasing hold while the clock is low continues the transfer from that bit.

Top module: `spi_hold_shifter`

## Requirements
- R1: After reset, `so_oe`, `rx_valid`, `frame_start`, `frame_end` and `mode3` are all 0.
- R2: A select falling edge (high to low, seen after synchronization) pulses `frame_start` for one cycle, clears the bit count and loads `tx_byte` into the transmit shifter. It also latches the synchronized clock level into `mode3`: 1 means the clock idled high.
- R3: A select rising edge pulses `frame_end` for one cycle. `frame_end` and `frame_start` are never high together.
- R4: `si_pin` is sampled on each rising clock edge, most significant bit first. Every eighth rising edge of a frame puts the assembled byte on `rx_byte` and pulses `rx_valid` for one cycle. `rx_byte` changes only in that cycle.
- R5: `so_out` is the MSB of the transmit shifter. A falling clock edge at bit count 0 reloads `tx_byte`, and any other falling edge shifts the shifter left by one.
- R6: With the clock idling high (`mode3`=1), the first falling edge does not advance the bit count, so the first rising edge captures bit 7 of the first byte.
- R7: While select is high, clock and data activity produces no `rx_valid`, and `so_oe` is 0.
- R8: Hold going low while the clock is low pauses the transfer. While paused, clock edges and select transitions are ignored (no `frame_start`, `frame_end` or `rx_valid`) and `so_oe` is 0. Hold going high while the clock is low resumes the transfer from the bit where it stopped.
- R9: A hold change made while the clock is high takes effect only once the clock is seen low. The falling edge that ends the high phase is still processed.
- R10: `so_oe` is 1 only when `tx_drive_en` is 1, select is low and the engine is not paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_pin | input | 1 | Serial clock pin |
| si_pin | input | 1 | Serial data in pin |
| cs_n_pin | input | 1 | Active-low select pin |
| hold_n_pin | input | 1 | Active-low hold pin |
| tx_byte | input | DATA_W | Next byte to transmit |
| tx_drive_en | input | 1 | Command logic wants the output driven |
| so_out | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial out pad |
| rx_byte | output | DATA_W | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| frame_start | output | 1 | One-cycle pulse on select falling |
| frame_end | output | 1 | One-cycle pulse on select rising |
| mode3 | output | 1 | Clock level latched at frame start |

## Verification
A bit count that drifts from the true position shows within one byte. `rx_valid` then fires on the wrong rising edge, and the falling edge that should reload `tx_byte` shifts instead, so both the received byte and the bits the master reads back are corrupted. A pause flag that is set or cleared at the wrong moment shows as `so_oe` toggling during a hold, or as a byte that arrives with a bit doubled or missing after the resume. A behavioural model in the bench, fed the same pins, catches any of these in the cycle they appear.

// File: rtl/spi_hold_shifter.sv
module spi_hold_shifter #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_pin,
  input  logic              si_pin,
  input  logic              cs_n_pin,
  input  logic              hold_n_pin,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_drive_en,
  output logic              so_out,
  output logic              so_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              frame_start,
  output logic              frame_end,
  output logic              mode3
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sck_q, si_q, csn_q, hld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      si_q  <= '0;
      csn_q <= '1;
      hld_q <= '1;
    end else begin
      sck_q <= {sck_q[SYNC_STAGES-2:0], sck_pin};
      si_q  <= {si_q[SYNC_STAGES-2:0], si_pin};
      csn_q <= {csn_q[SYNC_STAGES-2:0], cs_n_pin};
      hld_q <= {hld_q[SYNC_STAGES-2:0], hold_n_pin};
    end
  end

  wire sck_s = sck_q[SYNC_STAGES-1];
  wire si_s  = si_q[SYNC_STAGES-1];
  wire csn_s = csn_q[SYNC_STAGES-1];
  wire hld_s = hld_q[SYNC_STAGES-1];

  logic              sck_d, sel, held;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh;

  wire rise = sck_s & ~sck_d;
  wire fall = ~sck_s & sck_d;
  wire live = sel & ~held;
  wire [DATA_W-1:0] rx_next = {rx_sh[DATA_W-2:0], si_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d       <= 1'b0;
      sel         <= 1'b0;
      held        <= 1'b0;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      rx_byte     <= '0;
      rx_valid    <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
      mode3       <= 1'b0;
    end else begin
      sck_d       <= sck_s;
      rx_valid    <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;

      if (live && rise) begin
        rx_sh   <= rx_next;
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          rx_byte  <= rx_next;
          rx_valid <= 1'b1;
        end
      end

      if (live && fall)
        tx_sh <= (bit_cnt == '0) ? tx_byte : {tx_sh[DATA_W-2:0], 1'b0};

      if (!held) begin
        sel <= ~csn_s;
        if (!csn_s && !sel) begin
          frame_start <= 1'b1;
          bit_cnt     <= '0;
          mode3       <= sck_s;
          tx_sh       <= tx_byte;
        end
        if (csn_s && sel)
          frame_end <= 1'b1;
      end

      if (!sck_s)
        held <= ~hld_s;
    end
  end

  assign so_out = tx_sh[DATA_W-1];
  assign so_oe  = tx_drive_en & sel & ~held;
endmodule

// File: rtl/spi_hold_shifter_chk.sv
module spi_hold_shifter_chk #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sck_pin,
  input logic              cs_n_pin,
  input logic              hold_n_pin,
  input logic              so_oe,
  input logic [DATA_W-1:0] rx_byte,
  input logic              rx_valid,
  input logic              frame_start,
  input logic              frame_end
);
  localparam int SETTLE = SYNC_STAGES + 3;

  int hold_quiet, idle_quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_quiet <= 0;
      idle_quiet <= 0;
    end else begin
      hold_quiet <= (!hold_n_pin && !sck_pin) ? ((hold_quiet < SETTLE) ? hold_quiet + 1 : hold_quiet) : 0;
      idle_quiet <= (cs_n_pin && hold_n_pin && !sck_pin) ? ((idle_quiet < SETTLE) ? idle_quiet + 1 : idle_quiet) : 0;
    end
  end

  p_fs_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n) frame_start |=> !frame_start);
  p_fe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n) frame_end |=> !frame_end);
  p_fe_fs_excl_r3: assert property (@(posedge clk) disable iff (!rst_n) !(frame_start && frame_end));
  p_rv_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid);
  p_rx_only_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rx_byte) |-> rx_valid);
  p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rst_n) (idle_quiet >= SETTLE) |-> (!so_oe && !rx_valid));
  p_hold_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_quiet >= SETTLE) |-> (!so_oe && !rx_valid && !frame_start && !frame_end));
endmodule

bind spi_hold_shifter spi_hold_shifter_chk #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .cs_n_pin(cs_n_pin), .hold_n_pin(hold_n_pin),
  .so_oe(so_oe), .rx_byte(rx_byte), .rx_valid(rx_valid), .frame_start(frame_start), .frame_end(frame_end));

// File: tb/spi_hold_shifter_tb_top.sv
module spi_hold_shifter_tb_top;
  localparam int CLK_P = 10;
  localparam int SYNC  = 2;
  localparam int H     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck_pin = 1'b0, si_pin = 1'b0, cs_n_pin = 1'b1, hold_n_pin = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic tx_drive_en = 1'b0;
  logic so_out, so_oe, rx_valid, frame_start, frame_end, mode3;
  logic [7:0] rx_byte;

  always #(CLK_P/2) clk = ~clk;

  spi_hold_shifter #(.DATA_W(8), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .si_pin(si_pin), .cs_n_pin(cs_n_pin),
    .hold_n_pin(hold_n_pin), .tx_byte(tx_byte), .tx_drive_en(tx_drive_en),
    .so_out(so_out), .so_oe(so_oe), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .frame_start(frame_start), .frame_end(frame_end), .mode3(mode3));

  int checks = 0, fails = 0;
  int rv_cnt = 0, fs_cnt = 0, fe_cnt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit q_sck[$], q_si[$], q_csn[$], q_hld[$];
  bit m_prev, m_sel, m_held, m_fs, m_fe, m_rv, m_mode3;
  int m_cnt;
  logic [7:0] m_rx_sh, m_rx, m_tx;

  task automatic model_reset();
    q_sck = {}; q_si = {}; q_csn = {}; q_hld = {};
    for (int i = 0; i < SYNC; i++) begin
      q_sck.push_back(1'b0); q_si.push_back(1'b0); q_csn.push_back(1'b1); q_hld.push_back(1'b1);
    end
    m_prev = 0; m_sel = 0; m_held = 0; m_fs = 0; m_fe = 0; m_rv = 0; m_mode3 = 0;
    m_cnt = 0; m_rx_sh = 0; m_rx = 0; m_tx = 0;
  endtask

  task automatic model_step();
    bit s, d, c, h, rise, fall, live, held_old, sel_old;
    q_sck.push_back(sck_pin); s = q_sck.pop_front();
    q_si.push_back(si_pin);   d = q_si.pop_front();
    q_csn.push_back(cs_n_pin); c = q_csn.pop_front();
    q_hld.push_back(hold_n_pin); h = q_hld.pop_front();
    m_fs = 0; m_fe = 0; m_rv = 0;
    rise = s && !m_prev; fall = !s && m_prev; m_prev = s;
    held_old = m_held; sel_old = m_sel; live = sel_old && !held_old;
    if (live && rise) begin
      m_rx_sh = {m_rx_sh[6:0], d};
      if (m_cnt == 7) begin m_rx = m_rx_sh; m_rv = 1; end
      m_cnt = (m_cnt + 1) % 8;
    end
    if (live && fall) m_tx = (m_cnt == 0) ? tx_byte : (m_tx << 1);
    if (!held_old) begin
      if (!c && !sel_old) begin m_fs = 1; m_cnt = 0; m_mode3 = s; m_tx = tx_byte; end
      if (c && sel_old) m_fe = 1;
      m_sel = !c;
    end
    if (!s) m_held = !h;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
    #(CLK_P/4);
    if (!done) begin
      chk(frame_start == m_fs, "R2 frame_start", frame_start, m_fs);
      chk(mode3 == m_mode3, "R2 mode3", mode3, m_mode3);
      chk(frame_end == m_fe, "R3 frame_end", frame_end, m_fe);
      chk(rx_valid == m_rv, "R4 rx_valid", rx_valid, m_rv);
      chk(rx_byte == m_rx, "R4 rx_byte", rx_byte, m_rx);
      chk(so_out == m_tx[7], "R5 so_out", so_out, m_tx[7]);
      chk(so_oe == (tx_drive_en && m_sel && !m_held), "R10 so_oe", so_oe, tx_drive_en && m_sel && !m_held);
      if (rx_valid) rv_cnt++;
      if (frame_start) fs_cnt++;
      if (frame_end) fe_cnt++;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(input bit b, output bit so_b);
    sck_pin = 1'b0; si_pin = b;
    wt(H);
    so_b = so_out;
    sck_pin = 1'b1;
    wt(H);
  endtask

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      bit_clk(mo[i], b);
      mi[i] = b;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] mi;
    int rv0, fs0, fe0;
    bit b;
    wt(5);
    chk(!so_oe && !rx_valid && !frame_start && !frame_end && !mode3, "R1 reset outputs", {so_oe, rx_valid, mode3}, 0);
    rst_n = 1'b1;
    wt(4);

    // mode 0, two bytes
    tx_byte = 8'h3C; tx_drive_en = 1'b1;
    cs_n_pin = 1'b0; wt(2*H);
    chk(mode3 == 1'b0, "R2 mode0 latched", mode3, 0);
    chk(fs_cnt == 1, "R2 one frame_start", fs_cnt, 1);
    chk(so_oe == 1'b1, "R10 driven in frame", so_oe, 1);
    xfer(8'hA5, mi);
    chk(mi == 8'h3C, "R5 first byte out", mi, 8'h3C);
    chk(rx_byte == 8'hA5, "R4 first byte in", rx_byte, 8'hA5);
    tx_byte = 8'hC3;
    xfer(8'h5A, mi);
    chk(mi == 8'hC3, "R5 second byte out", mi, 8'hC3);
    chk(rx_byte == 8'h5A, "R4 second byte in", rx_byte, 8'h5A);
    chk(rv_cnt == 2, "R4 two strobes", rv_cnt, 2);
    tx_drive_en = 1'b0; wt(2);
    chk(so_oe == 1'b0, "R10 enable low floats", so_oe, 0);
    tx_drive_en = 1'b1;
    sck_pin = 1'b0; wt(H);
    cs_n_pin = 1'b1; wt(2*H);
    chk(fe_cnt == 1, "R3 frame_end pulse", fe_cnt, 1);
    chk(so_oe == 1'b0, "R10 deselected floats", so_oe, 0);

    // mode 3
    sck_pin = 1'b1; wt(H);
    tx_byte = 8'h96;
    cs_n_pin = 1'b0; wt(2*H);
    chk(mode3 == 1'b1, "R6 mode3 latched", mode3, 1);
    rv0 = rv_cnt;
    xfer(8'h81, mi);
    chk(rx_byte == 8'h81, "R6 first rise is bit 7", rx_byte, 8'h81);
    chk(mi == 8'h96, "R6 mode3 byte out", mi, 8'h96);
    chk(rv_cnt == rv0 + 1, "R6 one strobe", rv_cnt, rv0 + 1);
    cs_n_pin = 1'b1; wt(2*H);

    // deselected activity
    sck_pin = 1'b0; wt(H);
    rv0 = rv_cnt;
    for (int i = 0; i < 16; i++) begin
      si_pin = i[0]; sck_pin = ~sck_pin; wt(H);
    end
    chk(rv_cnt == rv0, "R7 no strobe while deselected", rv_cnt, rv0);
    chk(so_oe == 1'b0, "R7 floats while deselected", so_oe, 0);

    // hold with clock low, select toggled during hold
    sck_pin = 1'b0; tx_byte = 8'h6B; wt(H);
    cs_n_pin = 1'b0; wt(2*H);
    fs0 = fs_cnt; fe0 = fe_cnt; rv0 = rv_cnt;
    for (int i = 7; i >= 4; i--) begin bit_clk(i[0] ^ 1'b1, b); mi[i] = b; end
    sck_pin = 1'b0; wt(H);
    hold_n_pin = 1'b0; wt(H);
    chk(so_oe == 1'b0, "R8 floats in hold", so_oe, 0);
    for (int i = 0; i < 6; i++) begin sck_pin = ~sck_pin; wt(H); end
    cs_n_pin = 1'b1; wt(2*H);
    cs_n_pin = 1'b0; wt(2*H);
    chk(fs_cnt == fs0 && fe_cnt == fe0, "R8 select ignored in hold", fs_cnt + fe_cnt, fs0 + fe0);
    chk(rv_cnt == rv0, "R8 clock ignored in hold", rv_cnt, rv0);
    hold_n_pin = 1'b1; wt(H);
    chk(so_oe == 1'b1, "R8 resumes driving", so_oe, 1);
    for (int i = 3; i >= 0; i--) begin bit_clk(i[0] ^ 1'b1, b); mi[i] = b; end
    chk(rx_byte == 8'h55, "R8 byte intact after hold", rx_byte, 8'h55);
    chk(mi == 8'h6B, "R8 output intact after hold", mi, 8'h6B);

    // hold asserted with clock high is deferred
    tx_byte = 8'hE1;
    for (int i = 7; i >= 4; i--) begin bit_clk(1'b1, b); mi[i] = b; end
    hold_n_pin = 1'b0; wt(H);
    chk(so_oe == 1'b1, "R9 hold deferred while clock high", so_oe, 1);
    sck_pin = 1'b0; wt(H);
    chk(so_oe == 1'b0, "R9 hold active once clock low", so_oe, 0);
    sck_pin = 1'b1; wt(H); sck_pin = 1'b0; wt(H);
    hold_n_pin = 1'b1; wt(H);
    for (int i = 3; i >= 0; i--) begin bit_clk(1'b0, b); mi[i] = b; end
    chk(rx_byte == 8'hF0, "R9 byte intact", rx_byte, 8'hF0);
    chk(mi == 8'hE1, "R9 output intact", mi, 8'hE1);
    sck_pin = 1'b0; wt(H);
    cs_n_pin = 1'b1; wt(3*H);
    finish_run();
  end
endmodule